// File: doc/BRIEF.md
# Trace and Breakpoint Exception Sequencer

This block sits beside the retirement stage of a processor core and decides, for every completed instruction, whether an exception must be taken and what goes into its stack frame. It watches a retirement strobe together with a class tag for the retiring instruction: plain, halt-with-status-load (STOP) or system call (TRAP). It also sees the immediate status word carried by a STOP, the live status register, the address of the retiring instruction and the address that follows it, and a hardware breakpoint trigger.

When an exception is due, the block raises a one-clock request. The request carries a vector number, the program counter and status word to be written into the frame, and the status word the core must load for the handler. A STOP that does not end in an exception still hands its immediate to the core through the same status-update strobe. Only one exception is ever produced per event. A breakpoint takes precedence over everything else. A TRAP suppresses the trace that would otherwise follow it, and leaves the trace bit visible in the stacked status so that its handler can pass control on.

Top module: `trace_exc_seq`

## Requirements
- R1: A plain instruction (class code 0) retiring while status bit 15 (trace) is set produces an exception with vector 9. Its stacked PC is the next-instruction address and its stacked status is the live status. As a result, the instruction before a STOP stacks the STOP's own address.
- R2: A plain instruction retiring with status bit 15 clear produces no exception.
- R3: A STOP (class code 1) loads its immediate into the status. If bit 15 is set in either the live status or the immediate, it also produces a vector 9 exception whose stacked PC is the next-instruction address and whose stacked status is the immediate.
- R4: A STOP with bit 15 clear in both the live status and the immediate produces no exception, but pulses the status-update strobe with the immediate as the new status.
- R5: A TRAP (class code 2) with number n always produces an exception with vector 32+n, stacked PC equal to the next-instruction address and stacked status equal to the live status, bit 15 included. No trace exception follows it.
- R6: An asserted breakpoint trigger produces an exception with vector 12, whatever else retires in the same cycle. Its stacked PC is the next-instruction address when an instruction retires and the current address otherwise. Its stacked status is the status in effect after the retiring instruction.
- R7: For every exception, the new status equals the stacked status with bit 15 cleared and bit 13 (supervisor) set. The master-state bit 12 and the priority mask bits 10:8 are unchanged.
- R8: All outputs are registered and appear on the clock after the causing inputs. Each request lasts exactly one clock per event. During reset the request and status-update strobes are low.
- R9: A cycle with no retirement and no breakpoint produces neither a request nor a status update.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| retire_vld | input | 1 | An instruction completes this cycle |
| retire_cls | input | 2 | Class of the retiring instruction: 0 plain, 1 STOP, 2 TRAP |
| stop_imm | input | 16 | Immediate status word of a retiring STOP |
| sr_cur | input | 16 | Live status register |
| pc_cur | input | AW | Address of the retiring (or current) instruction |
| pc_next | input | AW | Address of the following instruction |
| trap_num | input | 4 | TRAP number of a retiring TRAP |
| bkpt_trig | input | 1 | Hardware breakpoint trigger |
| exc_req | output | 1 | One-clock exception request |
| exc_vec | output | 8 | Vector number, valid with exc_req |
| exc_pc | output | AW | PC for the stack frame, valid with exc_req |
| exc_sr | output | 16 | Status for the stack frame, valid with exc_req |
| sr_upd_vld | output | 1 | New status word is valid |
| sr_upd | output | 16 | Status word the core must load |

## Verification
On every cycle the assertions tie a breakpoint, a traced plain retirement and an idle cycle to the request one clock later. They also check that every request carries a legal vector and that the handler status clears trace and sets supervisor while keeping the master bit and priority mask. The STOP rules are shown only by the bench's scenarios: tracing that is switched on by the immediate alone, a STOP that clears trace, and the plain status load without an exception. The same holds for a TRAP that hides a pending trace and for the breakpoint beating a same-cycle STOP or TRAP, which the reference model compares on every clock.

// File: rtl/trc_pkg.sv
package trc_pkg;
  localparam int SRW     = 16;
  localparam int SR_T    = 15;
  localparam int SR_S    = 13;
  localparam int SR_M    = 12;
  localparam int IPL_HI  = 10;
  localparam int IPL_LO  = 8;
  localparam int VECW    = 8;

  typedef enum logic [1:0] {
    CLS_PLAIN   = 2'd0,
    CLS_HALT    = 2'd1,
    CLS_SYSCALL = 2'd2
  } icls_e;

  typedef enum logic [1:0] {
    CAUSE_NONE  = 2'd0,
    CAUSE_TRACE = 2'd1,
    CAUSE_TRAP  = 2'd2,
    CAUSE_BKPT  = 2'd3
  } cause_e;
endpackage

// File: rtl/trc_arbiter.sv
module trc_arbiter
  import trc_pkg::*;
(
  input  logic       retire_vld,
  input  logic [1:0] retire_cls,
  input  logic       sr_t_live,
  input  logic       imm_t,
  input  logic       bkpt_trig,
  output cause_e     cause,
  output logic       halt_load
);
  logic is_halt;
  logic is_sys;
  logic is_plain;
  logic trace_due;

  always_comb begin
    is_halt  = retire_vld && (retire_cls == CLS_HALT);
    is_sys   = retire_vld && (retire_cls == CLS_SYSCALL);
    is_plain = retire_vld && !is_halt && !is_sys;
    // STOP traces if trace was already on or the new status turns it on
    trace_due = (is_plain && sr_t_live) || (is_halt && (sr_t_live || imm_t));
    halt_load = is_halt;
    if (bkpt_trig)      cause = CAUSE_BKPT;
    else if (is_sys)    cause = CAUSE_TRAP;
    else if (trace_due) cause = CAUSE_TRACE;
    else                cause = CAUSE_NONE;
  end
endmodule

// File: rtl/trc_frame_build.sv
module trc_frame_build
  import trc_pkg::*;
#(
  parameter int AW        = 32,
  parameter int TRACE_VEC = 9,
  parameter int BKPT_VEC  = 12,
  parameter int TRAP_BASE = 32,
  parameter int TRAPW     = 4
) (
  input  cause_e           cause,
  input  logic             retire_vld,
  input  logic             halt_load,
  input  logic [SRW-1:0]   sr_cur,
  input  logic [SRW-1:0]   stop_imm,
  input  logic [AW-1:0]    pc_cur,
  input  logic [AW-1:0]    pc_next,
  input  logic [TRAPW-1:0] trap_num,
  output logic             take,
  output logic [VECW-1:0]  vec,
  output logic [AW-1:0]    frame_pc,
  output logic [SRW-1:0]   frame_sr,
  output logic             new_sr_vld,
  output logic [SRW-1:0]   new_sr
);
  localparam logic [VECW-1:0] TRACE_V = VECW'(TRACE_VEC);
  localparam logic [VECW-1:0] BKPT_V  = VECW'(BKPT_VEC);
  localparam logic [VECW-1:0] TRAP_V  = VECW'(TRAP_BASE);

  logic [SRW-1:0] sr_eff;
  logic [SRW-1:0] handler_sr;

  always_comb begin
    sr_eff = halt_load ? stop_imm : sr_cur;
    take   = (cause != CAUSE_NONE);
    unique case (cause)
      CAUSE_BKPT: begin
        vec      = BKPT_V;
        frame_pc = retire_vld ? pc_next : pc_cur;
        frame_sr = sr_eff;
      end
      CAUSE_TRAP: begin
        vec      = TRAP_V + VECW'(trap_num);
        frame_pc = pc_next;
        frame_sr = sr_cur;
      end
      CAUSE_TRACE: begin
        vec      = TRACE_V;
        frame_pc = pc_next;
        frame_sr = sr_eff;
      end
      default: begin
        vec      = '0;
        frame_pc = '0;
        frame_sr = '0;
      end
    endcase
    handler_sr          = frame_sr;
    handler_sr[SR_T]    = 1'b0;
    handler_sr[SR_S]    = 1'b1;
    new_sr_vld = take || halt_load;
    new_sr     = take ? handler_sr : stop_imm;
  end
endmodule

// File: rtl/trc_out_stage.sv
module trc_out_stage
  import trc_pkg::*;
#(
  parameter int AW = 32
) (
  input  logic            clk,
  input  logic            rst_n,
  input  logic            take,
  input  logic [VECW-1:0] vec,
  input  logic [AW-1:0]   frame_pc,
  input  logic [SRW-1:0]  frame_sr,
  input  logic            new_sr_vld,
  input  logic [SRW-1:0]  new_sr,
  output logic            exc_req,
  output logic [VECW-1:0] exc_vec,
  output logic [AW-1:0]   exc_pc,
  output logic [SRW-1:0]  exc_sr,
  output logic            sr_upd_vld,
  output logic [SRW-1:0]  sr_upd
);
  logic            req_d;
  logic            upd_d;
  logic            frame_en;
  logic            upd_en;

  always_comb begin
    req_d    = take;
    upd_d    = new_sr_vld;
    frame_en = take;
    upd_en   = new_sr_vld;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      exc_req    <= 1'b0;
      sr_upd_vld <= 1'b0;
    end else begin
      exc_req    <= req_d;
      sr_upd_vld <= upd_d;
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      exc_vec <= '0;
      exc_pc  <= '0;
      exc_sr  <= '0;
    end else if (frame_en) begin
      exc_vec <= vec;
      exc_pc  <= frame_pc;
      exc_sr  <= frame_sr;
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      sr_upd <= '0;
    end else if (upd_en) begin
      sr_upd <= new_sr;
    end
  end
endmodule

// File: rtl/trace_exc_seq.sv
module trace_exc_seq
  import trc_pkg::*;
#(
  parameter int AW        = 32,
  parameter int TRACE_VEC = 9,
  parameter int BKPT_VEC  = 12,
  parameter int TRAP_BASE = 32,
  parameter int TRAPW     = 4
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             retire_vld,
  input  logic [1:0]       retire_cls,
  input  logic [15:0]      stop_imm,
  input  logic [15:0]      sr_cur,
  input  logic [AW-1:0]    pc_cur,
  input  logic [AW-1:0]    pc_next,
  input  logic [TRAPW-1:0] trap_num,
  input  logic             bkpt_trig,
  output logic             exc_req,
  output logic [7:0]       exc_vec,
  output logic [AW-1:0]    exc_pc,
  output logic [15:0]      exc_sr,
  output logic             sr_upd_vld,
  output logic [15:0]      sr_upd
);
  cause_e          cause;
  logic            halt_load;
  logic            take;
  logic [VECW-1:0] vec;
  logic [AW-1:0]   frame_pc;
  logic [SRW-1:0]  frame_sr;
  logic            new_sr_vld;
  logic [SRW-1:0]  new_sr;

  trc_arbiter u_arb (
    .retire_vld (retire_vld),
    .retire_cls (retire_cls),
    .sr_t_live  (sr_cur[SR_T]),
    .imm_t      (stop_imm[SR_T]),
    .bkpt_trig  (bkpt_trig),
    .cause      (cause),
    .halt_load  (halt_load)
  );

  trc_frame_build #(
    .AW(AW), .TRACE_VEC(TRACE_VEC), .BKPT_VEC(BKPT_VEC),
    .TRAP_BASE(TRAP_BASE), .TRAPW(TRAPW)
  ) u_frame (
    .cause      (cause),
    .retire_vld (retire_vld),
    .halt_load  (halt_load),
    .sr_cur     (sr_cur),
    .stop_imm   (stop_imm),
    .pc_cur     (pc_cur),
    .pc_next    (pc_next),
    .trap_num   (trap_num),
    .take       (take),
    .vec        (vec),
    .frame_pc   (frame_pc),
    .frame_sr   (frame_sr),
    .new_sr_vld (new_sr_vld),
    .new_sr     (new_sr)
  );

  trc_out_stage #(.AW(AW)) u_out (
    .clk        (clk),
    .rst_n      (rst_n),
    .take       (take),
    .vec        (vec),
    .frame_pc   (frame_pc),
    .frame_sr   (frame_sr),
    .new_sr_vld (new_sr_vld),
    .new_sr     (new_sr),
    .exc_req    (exc_req),
    .exc_vec    (exc_vec),
    .exc_pc     (exc_pc),
    .exc_sr     (exc_sr),
    .sr_upd_vld (sr_upd_vld),
    .sr_upd     (sr_upd)
  );
endmodule

// File: rtl/trace_exc_seq_chk.sv
module trace_exc_seq_chk #(
  parameter int AW = 32
) (
  input logic          clk,
  input logic          rst_n,
  input logic          retire_vld,
  input logic [1:0]    retire_cls,
  input logic [15:0]   sr_cur,
  input logic [AW-1:0] pc_next,
  input logic          bkpt_trig,
  input logic          exc_req,
  input logic [7:0]    exc_vec,
  input logic [AW-1:0] exc_pc,
  input logic [15:0]   exc_sr,
  input logic          sr_upd_vld,
  input logic [15:0]   sr_upd
);
  logic past_ok;
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) past_ok <= 1'b0;
    else        past_ok <= 1'b1;
  end

  // R6: breakpoint always yields vector 12 next clock
  a_r6_bkpt_vector: assert property (@(posedge clk) disable iff (!rst_n)
    (past_ok && $past(bkpt_trig)) |-> (exc_req && exc_vec == 8'd12));

  // R1: traced plain retirement stacks the next address with vector 9
  a_r1_plain_trace: assert property (@(posedge clk) disable iff (!rst_n)
    (past_ok && $past(retire_vld && retire_cls == 2'd0 && sr_cur[15] && !bkpt_trig))
      |-> (exc_req && exc_vec == 8'd9 && exc_pc == $past(pc_next) && exc_sr == $past(sr_cur)));

  // R9: idle cycle gives nothing
  a_r9_idle_quiet: assert property (@(posedge clk) disable iff (!rst_n)
    (past_ok && $past(!retire_vld && !bkpt_trig)) |-> (!exc_req && !sr_upd_vld));

  // R7: handler status clears trace, sets supervisor, keeps M and mask
  a_r7_handler_sr: assert property (@(posedge clk) disable iff (!rst_n)
    exc_req |-> (sr_upd_vld && !sr_upd[15] && sr_upd[13] && sr_upd[12] == exc_sr[12]
                 && sr_upd[10:8] == exc_sr[10:8]));

  // R5: every request carries a legal vector
  a_r5_vec_legal: assert property (@(posedge clk) disable iff (!rst_n)
    exc_req |-> (exc_vec == 8'd9 || exc_vec == 8'd12 || (exc_vec >= 8'd32 && exc_vec <= 8'd47)));

  // R8: a request is a single clock unless a new event caused the next one
  a_r8_single_pulse: assert property (@(posedge clk) disable iff (!rst_n)
    (past_ok && $past(exc_req) && $past(!retire_vld && !bkpt_trig)) |-> !exc_req);
endmodule

bind trace_exc_seq trace_exc_seq_chk #(.AW(AW)) u_chk (
  .clk        (clk),
  .rst_n      (rst_n),
  .retire_vld (retire_vld),
  .retire_cls (retire_cls),
  .sr_cur     (sr_cur),
  .pc_next    (pc_next),
  .bkpt_trig  (bkpt_trig),
  .exc_req    (exc_req),
  .exc_vec    (exc_vec),
  .exc_pc     (exc_pc),
  .exc_sr     (exc_sr),
  .sr_upd_vld (sr_upd_vld),
  .sr_upd     (sr_upd)
);

// File: tb/test_trace_exc_seq.sv
module test_trace_exc_seq;
  localparam int AW = 32;

  logic          clk;
  logic          rst_n;
  logic          retire_vld;
  logic [1:0]    retire_cls;
  logic [15:0]   stop_imm;
  logic [15:0]   sr_cur;
  logic [AW-1:0] pc_cur;
  logic [AW-1:0] pc_next;
  logic [3:0]    trap_num;
  logic          bkpt_trig;
  logic          exc_req;
  logic [7:0]    exc_vec;
  logic [AW-1:0] exc_pc;
  logic [15:0]   exc_sr;
  logic          sr_upd_vld;
  logic [15:0]   sr_upd;

  int checks = 0;
  int errors = 0;
  bit done = 0;

  typedef struct {
    bit          req;
    int          vec;
    logic [31:0] pc;
    logic [15:0] sr;
    bit          upd;
    logic [15:0] nsr;
    string       tag;
  } exp_t;
  exp_t q[$];

  trace_exc_seq #(.AW(AW)) i_trace_exc_seq (
    .clk(clk), .rst_n(rst_n), .retire_vld(retire_vld), .retire_cls(retire_cls),
    .stop_imm(stop_imm), .sr_cur(sr_cur), .pc_cur(pc_cur), .pc_next(pc_next),
    .trap_num(trap_num), .bkpt_trig(bkpt_trig), .exc_req(exc_req), .exc_vec(exc_vec),
    .exc_pc(exc_pc), .exc_sr(exc_sr), .sr_upd_vld(sr_upd_vld), .sr_upd(sr_upd)
  );

  initial clk = 0;
  always #10 clk = ~clk;

  task automatic compare(exp_t e);
    checks++;
    if (exc_req !== e.req || sr_upd_vld !== e.upd) begin
      errors++;
      $display("FAIL %s: req/upd %0b/%0b expected %0b/%0b", e.tag, exc_req, sr_upd_vld, e.req, e.upd);
      return;
    end
    if (e.req && (int'(exc_vec) != e.vec || exc_pc !== e.pc || exc_sr !== e.sr)) begin
      errors++;
      $display("FAIL %s: vec %0d pc %h sr %h expected vec %0d pc %h sr %h",
               e.tag, exc_vec, exc_pc, exc_sr, e.vec, e.pc, e.sr);
    end
    if (e.upd && sr_upd !== e.nsr) begin
      errors++;
      $display("FAIL %s: new sr %h expected %h", e.tag, sr_upd, e.nsr);
    end
  endtask

  // one cycle: check previous result, then drive new inputs and predict
  task automatic step(bit v, int cls, logic [15:0] imm, logic [15:0] sr,
                      logic [31:0] pcc, logic [31:0] pcn, int tn, bit bk);
    exp_t e;
    logic [15:0] eff;
    @(negedge clk);
    if (q.size() > 0) compare(q.pop_front());
    retire_vld = v; retire_cls = 2'(cls); stop_imm = imm; sr_cur = sr;
    pc_cur = pcc; pc_next = pcn; trap_num = 4'(tn); bkpt_trig = bk;
    eff = (v && cls == 1) ? imm : sr;
    e = '{req:0, vec:0, pc:0, sr:0, upd:0, nsr:0, tag:"R9"};
    if (bk) begin
      e.req = 1; e.vec = 12; e.pc = v ? pcn : pcc; e.sr = eff; e.tag = "R6";
    end else if (v && cls == 2) begin
      e.req = 1; e.vec = 32 + tn; e.pc = pcn; e.sr = sr; e.tag = "R5";
    end else if (v && cls == 1 && (sr[15] || imm[15])) begin
      e.req = 1; e.vec = 9; e.pc = pcn; e.sr = imm; e.tag = "R3";
    end else if (v && cls == 0 && sr[15]) begin
      e.req = 1; e.vec = 9; e.pc = pcn; e.sr = sr; e.tag = "R1";
    end else if (v && cls == 0) e.tag = "R2";
    if (e.req) begin
      e.upd = 1; e.nsr = (e.sr & 16'h7fff) | 16'h2000;
      if (e.tag == "R1") e.tag = "R1/R7";
    end else if (v && cls == 1) begin
      e.upd = 1; e.nsr = imm; e.tag = "R4";
    end
    q.push_back(e);
  endtask

  initial begin
    int unsigned cyc = 0;
    forever begin
      @(posedge clk);
      cyc++;
      if (cyc > 20000 && !done) begin
        errors++;
        $display("FAIL watchdog: cycles %0d expected below 20000", cyc);
        $display("Simulation finished: %0d checks, %0d errors", checks, errors);
        $finish;
      end
    end
  end

  initial begin
    rst_n = 0; retire_vld = 0; retire_cls = 0; stop_imm = 0; sr_cur = 0;
    pc_cur = 0; pc_next = 0; trap_num = 0; bkpt_trig = 0;
    repeat (3) @(negedge clk);
    checks++;
    if (exc_req !== 1'b0 || sr_upd_vld !== 1'b0) begin
      errors++;
      $display("FAIL R8: reset req/upd %0b/%0b expected 0/0", exc_req, sr_upd_vld);
    end
    rst_n = 1;
    // R2 untraced plain, R1 traced plain (also the one before a STOP)
    step(1, 0, 16'h0000, 16'h2700, 32'h100, 32'h104, 0, 0);
    step(1, 0, 16'h0000, 16'ha700, 32'h104, 32'h108, 0, 0);
    // R3 STOP while tracing, immediate clears trace
    step(1, 1, 16'h2500, 16'ha700, 32'h108, 32'h10c, 0, 0);
    // R3 STOP with tracing off, immediate sets trace
    step(1, 1, 16'h9300, 16'h2000, 32'h200, 32'h204, 0, 0);
    // R4 STOP without trace anywhere
    step(1, 1, 16'h2400, 16'h2000, 32'h300, 32'h304, 0, 0);
    // R5 TRAP in trace mode, and TRAP 15
    step(1, 2, 16'h0000, 16'h8000, 32'h400, 32'h402, 3, 0);
    step(1, 2, 16'h0000, 16'h1000, 32'h410, 32'h412, 15, 0);
    // R6 breakpoint idle, with traced plain, with STOP, with TRAP
    step(0, 0, 16'h0000, 16'h1500, 32'h500, 32'h504, 0, 1);
    step(1, 0, 16'h0000, 16'h9700, 32'h510, 32'h514, 0, 1);
    step(1, 1, 16'hb600, 16'h2000, 32'h520, 32'h524, 0, 1);
    step(1, 2, 16'h0000, 16'h8000, 32'h530, 32'h532, 5, 1);
    // R9 idle with trace set, R8 back-to-back traced
    step(0, 0, 16'h0000, 16'h8000, 32'h600, 32'h604, 0, 0);
    step(1, 0, 16'h0000, 16'h8000, 32'h604, 32'h608, 0, 0);
    step(1, 0, 16'h0000, 16'h8000, 32'h608, 32'h60c, 0, 0);
    step(0, 0, 16'h0000, 16'h0000, 32'h0, 32'h0, 0, 0);
    // mixed pseudo-random traffic
    for (int i = 0; i < 400; i++) begin
      logic [15:0] s = 16'($urandom);
      logic [31:0] p = $urandom;
      step($urandom % 4 != 0, int'($urandom % 3), 16'($urandom), s,
           p, p + 32'd4, int'($urandom % 16), $urandom % 8 == 0);
    end
    step(0, 0, 16'h0, 16'h0, 32'h0, 32'h0, 0, 0);
    @(negedge clk);
    if (q.size() > 0) compare(q.pop_front());
    done = 1;
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end
endmodule